// File: doc/BRIEF.md
# Trigger-Controlled Prescaled Timer Counter

This block is the counting core of a general-purpose timer. A clock-source selector picks between no clock, the block clock and an external clock. The external clock is synchronised and only its rising edges advance the count. A power-of-two prescaler divides the chosen source before it reaches an up-counter. The up-counter returns to zero after it reaches a programmable modulo value, and it raises a sticky overflow flag at that point.

A selectable trigger, one of sixteen inputs, can control the counter in four ways, and each one has its own enable. The trigger can hold the counter until the first trigger arrives. It can zero the counter on a trigger rising edge. It can halt counting while the trigger stays high. A separate enable stops the counter for good after its first overflow. Doze and debug inputs can freeze the count. A synchronous software reset clears all internal state, and the configuration inputs keep their values.

A readback of the effective clock source tells software when a shutdown has completed. After the source is set to off, the readback keeps its old value until the current prescaled period has ended and the counter has really stopped.

Top module: `tmr_core`

## Requirements
- R1: The count starts at 0. It advances by one on each prescaled tick, and on the tick after it equals `modulo` it becomes 0.
- R2: `ovf_flag` sets on the tick that wraps the count to 0. A one-cycle `ovf_clr` pulse clears it, and a new overflow in the same cycle wins. `ovf_irq` is high exactly when both `ovf_flag` and `ovf_irq_en` are high.
- R3: A `prescale` value p (0 to 7) makes the count advance once every 2^p source ticks.
- R4: For `clk_mode`, 0 means no counting, 1 counts the block clock on every cycle, and 2 counts rising edges of `ext_clk` after a two-flop synchroniser. The value 3 does not count.
- R5: `clk_mode_rb` takes a nonzero `clk_mode` one cycle after it is applied. After `clk_mode` becomes 0, the counter completes its current prescaled period, and `clk_mode_rb` reads 0 one cycle after that. From then on the count holds.
- R6: The active trigger is `trig_in[trig_sel]`, where `trig_sel` is 4 bits wide. No other trigger input has any effect.
- R7: With `start_on_trig` set, the counter stays at its value until the active trigger has been high while the source is on. Without it, counting starts as soon as the source is on.
- R8: With `reload_on_trig` set, a rising edge of the active trigger zeroes the count and the prescaler on the next clock. A trigger that stays high does not reload again.
- R9: With `pause_on_trig` set, the count holds on every cycle in which the active trigger is high.
- R10: With `stop_on_ovf` set, the count stays at 0 after its first overflow. Turning the clock source off and back on re-arms the counter.
- R11: The count holds while `doze` and `doze_pause` are both high, and while `debug` is high and `debug_run` is low.
- R12: A one-cycle `sw_reset` clears the count, the prescaler, the overflow flag, the readback and the trigger state. Counting then resumes from the unchanged configuration inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Synchronous software reset of all state |
| clk_mode | input | 2 | Clock source: 0 off, 1 block clock, 2 external |
| ext_clk | input | 1 | External count clock, asynchronous |
| prescale | input | 3 | Divide by 2^prescale |
| modulo | input | W | Terminal count value |
| trig_in | input | 16 | Trigger inputs |
| trig_sel | input | 4 | Index of the active trigger |
| start_on_trig | input | 1 | Wait for the trigger before counting |
| reload_on_trig | input | 1 | Zero the count on a trigger rising edge |
| pause_on_trig | input | 1 | Hold the count while the trigger is high |
| stop_on_ovf | input | 1 | Stop after the first overflow |
| doze | input | 1 | Chip is in doze state |
| doze_pause | input | 1 | Freeze the count in doze |
| debug | input | 1 | Chip is halted in debug |
| debug_run | input | 1 | Keep counting in debug |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| count | output | W | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| clk_mode_rb | output | 2 | Effective clock source readback |

## Verification
The properties check on every cycle that the count only steps by one or falls to zero, that the flag rises only together with a zero count, and that the count holds whenever pause, doze or debug freezing applies or the source is fully off. They also check that an overflow under stop-on-overflow leaves the count at zero. Only the directed scenarios can show the exact prescaler period, the delayed clearing of the readback at a period boundary, and how far the synchroniser delays external edges. The scenarios also cover start, reload and select behaviour, which needs a specific trigger history.

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W     = 16,
  parameter int NTRIG = 16,
  parameter int PW    = 7,
  localparam int SW   = $clog2(NTRIG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_reset,
  input  logic [1:0]    clk_mode,
  input  logic          ext_clk,
  input  logic [2:0]    prescale,
  input  logic [W-1:0]  modulo,
  input  logic [NTRIG-1:0] trig_in,
  input  logic [SW-1:0] trig_sel,
  input  logic          start_on_trig,
  input  logic          reload_on_trig,
  input  logic          pause_on_trig,
  input  logic          stop_on_ovf,
  input  logic          doze,
  input  logic          doze_pause,
  input  logic          debug,
  input  logic          debug_run,
  input  logic          ovf_clr,
  input  logic          ovf_irq_en,
  output logic [W-1:0]  count,
  output logic          ovf_flag,
  output logic          ovf_irq,
  output logic [1:0]    clk_mode_rb
);
  logic [1:0]    mode_q;
  logic [2:0]    ext_sy;
  logic          trig_q, started, halted, ovf_q;
  logic [PW-1:0] pre_q;
  logic [W-1:0]  cnt_q;

  wire          trig      = trig_in[trig_sel];
  wire          trig_rise = trig & ~trig_q;
  wire          ext_rise  = ext_sy[1] & ~ext_sy[2];
  wire          frozen    = (doze & doze_pause) | (debug & ~debug_run);
  wire          gate_ok   = (started | ~start_on_trig) & ~halted & ~frozen
                            & ~(pause_on_trig & trig);
  wire          src_tick  = (mode_q == 2'd1) | ((mode_q == 2'd2) & ext_rise);
  wire [PW-1:0] pmask     = (PW'(1) << prescale) - PW'(1);
  wire          phase_zero = (pre_q & pmask) == '0;
  wire          stopping  = (clk_mode == 2'd0) & (mode_q != 2'd0)
                            & (phase_zero | ~gate_ok);
  wire          step      = src_tick & gate_ok & ~stopping;
  wire          cnt_en    = step & ((pre_q & pmask) == pmask);
  wire          reload    = reload_on_trig & trig_rise & (mode_q != 2'd0);
  wire          wrap      = ~reload & cnt_en & (cnt_q == modulo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; ext_sy <= '0; trig_q <= 1'b0; started <= 1'b0;
      halted <= 1'b0; ovf_q <= 1'b0; pre_q <= '0; cnt_q <= '0;
    end else if (sw_reset) begin
      mode_q <= '0; ext_sy <= '0; trig_q <= 1'b0; started <= 1'b0;
      halted <= 1'b0; ovf_q <= 1'b0; pre_q <= '0; cnt_q <= '0;
    end else begin
      ext_sy <= {ext_sy[1:0], ext_clk};
      trig_q <= trig;

      if (clk_mode != 2'd0)  mode_q <= clk_mode;
      else if (stopping)     mode_q <= 2'd0;

      if (mode_q == 2'd0) begin
        started <= 1'b0;
        halted  <= 1'b0;
      end else begin
        if (trig)                    started <= 1'b1;
        if (wrap && stop_on_ovf)     halted  <= 1'b1;
      end

      if (wrap)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;

      if (reload) begin
        cnt_q <= '0;
        pre_q <= '0;
      end else if (step) begin
        pre_q <= pre_q + PW'(1);
        if (cnt_en) cnt_q <= wrap ? '0 : cnt_q + W'(1);
      end
    end
  end

  assign count       = cnt_q;
  assign ovf_flag    = ovf_q;
  assign ovf_irq     = ovf_q & ovf_irq_en;
  assign clk_mode_rb = mode_q;
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk #(
  parameter int W     = 16,
  parameter int NTRIG = 16,
  parameter int SW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_reset,
  input logic [1:0]       clk_mode,
  input logic [1:0]       clk_mode_rb,
  input logic [NTRIG-1:0] trig_in,
  input logic [SW-1:0]    trig_sel,
  input logic             reload_on_trig,
  input logic             pause_on_trig,
  input logic             stop_on_ovf,
  input logic             doze,
  input logic             doze_pause,
  input logic             debug,
  input logic             debug_run,
  input logic [W-1:0]     count,
  input logic             ovf_flag
);
  wire quiet = !sw_reset && !reload_on_trig;

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count != $past(count) |-> (count == $past(count) + W'(1)) || (count == '0));

  p_flag_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> count == '0);

  p_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_mode == 2'd0 && clk_mode_rb == 2'd0 && quiet) |=> $stable(count));

  p_pause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_on_trig && trig_in[trig_sel] && quiet) |=> $stable(count));

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_flag) && stop_on_ovf && quiet) |=> count == '0);

  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (((doze && doze_pause) || (debug && !debug_run)) && quiet) |=> $stable(count));
endmodule

bind tmr_core tmr_core_chk #(.W(W), .NTRIG(NTRIG), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .clk_mode(clk_mode),
  .clk_mode_rb(clk_mode_rb), .trig_in(trig_in), .trig_sel(trig_sel),
  .reload_on_trig(reload_on_trig), .pause_on_trig(pause_on_trig),
  .stop_on_ovf(stop_on_ovf), .doze(doze), .doze_pause(doze_pause),
  .debug(debug), .debug_run(debug_run), .count(count), .ovf_flag(ovf_flag)
);

// File: tb/tb_tmr_core.sv
`timescale 1ns/1ps
module tb_tmr_core;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, sw_reset = 0;
  logic [1:0] clk_mode = 0;
  logic ext_clk = 0;
  logic [2:0] prescale = 0;
  logic [W-1:0] modulo = 0;
  logic [15:0] trig_in = 0;
  logic [3:0] trig_sel = 0;
  logic start_on_trig = 0, reload_on_trig = 0, pause_on_trig = 0, stop_on_ovf = 0;
  logic doze = 0, doze_pause = 0, debug = 0, debug_run = 0, ovf_clr = 0, ovf_irq_en = 0;
  logic [W-1:0] count;
  logic ovf_flag, ovf_irq;
  logic [1:0] clk_mode_rb;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_core #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .clk_mode(clk_mode),
    .ext_clk(ext_clk), .prescale(prescale), .modulo(modulo), .trig_in(trig_in),
    .trig_sel(trig_sel), .start_on_trig(start_on_trig),
    .reload_on_trig(reload_on_trig), .pause_on_trig(pause_on_trig),
    .stop_on_ovf(stop_on_ovf), .doze(doze), .doze_pause(doze_pause),
    .debug(debug), .debug_run(debug_run), .ovf_clr(ovf_clr),
    .ovf_irq_en(ovf_irq_en), .count(count), .ovf_flag(ovf_flag),
    .ovf_irq(ovf_irq), .clk_mode_rb(clk_mode_rb));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clean();
    clk_mode = 0; prescale = 0; trig_in = 0; trig_sel = 0;
    start_on_trig = 0; reload_on_trig = 0; pause_on_trig = 0; stop_on_ovf = 0;
    doze = 0; doze_pause = 0; debug = 0; debug_run = 0; ovf_clr = 0; ovf_irq_en = 0;
    sw_reset = 1; tick(1); sw_reset = 0;
  endtask

  task automatic t_reset();
    check("R12", "count after reset", count, 0);
    check("R2", "flag after reset", ovf_flag, 0);
    check("R5", "readback after reset", clk_mode_rb, 0);
  endtask

  task automatic t_wrap();
    clean(); modulo = 4; clk_mode = 1;
    tick(1);
    check("R5", "readback follows mode", clk_mode_rb, 1);
    check("R1", "count at start", count, 0);
    tick(4);
    check("R1", "count at modulo", count, 4);
    check("R2", "flag before wrap", ovf_flag, 0);
    tick(1);
    check("R1", "count wrapped", count, 0);
    check("R2", "flag on wrap", ovf_flag, 1);
    check("R2", "irq masked", ovf_irq, 0);
    ovf_irq_en = 1; #1;
    check("R2", "irq enabled", ovf_irq, 1);
    ovf_clr = 1; tick(1); ovf_clr = 0;
    check("R2", "flag cleared", ovf_flag, 0);
    check("R2", "irq after clear", ovf_irq, 0);
  endtask

  task automatic t_prescale_stop();
    clean(); modulo = 100; prescale = 2; clk_mode = 1;
    tick(1);
    tick(3);
    check("R3", "div4 before 4th tick", count, 0);
    tick(1);
    check("R3", "div4 first step", count, 1);
    tick(4);
    check("R3", "div4 second step", count, 2);
    tick(1);
    clk_mode = 0;
    tick(3);
    check("R5", "readback holds in period", clk_mode_rb, 1);
    check("R5", "period completes", count, 3);
    tick(1);
    check("R5", "readback off at boundary", clk_mode_rb, 0);
    tick(6);
    check("R4", "mode 0 holds count", count, 3);
    clean(); modulo = 100; prescale = 7; clk_mode = 1;
    tick(129);
    check("R3", "div128 one step", count, 1);
  endtask

  task automatic t_ext();
    clean(); modulo = 100; clk_mode = 2;
    for (int i = 0; i < 3; i++) begin
      ext_clk = 1; tick(5);
      ext_clk = 0; tick(5);
    end
    check("R4", "external rising edges", count, 3);
  endtask

  task automatic t_start();
    clean(); modulo = 100; start_on_trig = 1; trig_sel = 5; clk_mode = 1;
    tick(5);
    check("R7", "waits for trigger", count, 0);
    trig_in[3] = 1; tick(4); trig_in[3] = 0;
    check("R6", "unselected trigger ignored", count, 0);
    trig_in[5] = 1; tick(1); trig_in[5] = 0;
    tick(2);
    check("R7", "counts after trigger", count, 2);
    clean(); modulo = 100; clk_mode = 1;
    tick(4);
    check("R7", "immediate start", count, 3);
  endtask

  task automatic t_pause();
    clean(); modulo = 100; pause_on_trig = 1; trig_sel = 9; clk_mode = 1;
    tick(4);
    check("R9", "count before pause", count, 3);
    trig_in[9] = 1; tick(5);
    check("R9", "held while trigger high", count, 3);
    trig_in[9] = 0; tick(1);
    check("R9", "resumes", count, 4);
  endtask

  task automatic t_reload();
    clean(); modulo = 100; reload_on_trig = 1; trig_sel = 12; clk_mode = 1;
    tick(6);
    check("R8", "count before reload", count, 5);
    trig_in[12] = 1; tick(1);
    check("R8", "reloaded", count, 0);
    tick(1);
    check("R8", "held trigger no second reload", count, 1);
    trig_in[12] = 0; tick(1);
    check("R8", "continues", count, 2);
  endtask

  task automatic t_stop();
    clean(); modulo = 3; stop_on_ovf = 1; clk_mode = 1;
    tick(5);
    check("R10", "wrapped", count, 0);
    check("R10", "flag", ovf_flag, 1);
    tick(5);
    check("R10", "stays stopped", count, 0);
    clk_mode = 0; tick(1);
    check("R5", "stopped counter reads off", clk_mode_rb, 0);
    clk_mode = 1; tick(3);
    check("R10", "re-armed", count, 2);
  endtask

  task automatic t_freeze();
    clean(); modulo = 100; clk_mode = 1;
    tick(3);
    doze = 1; tick(2);
    check("R11", "doze without pause runs", count, 4);
    doze_pause = 1; tick(3);
    check("R11", "doze pause holds", count, 4);
    doze = 0; debug = 1; tick(3);
    check("R11", "debug holds", count, 4);
    debug_run = 1; tick(2);
    check("R11", "debug run counts", count, 6);
  endtask

  task automatic t_swreset();
    clean(); modulo = 2; clk_mode = 1;
    tick(5);
    check("R12", "flag set before reset", ovf_flag, 1);
    sw_reset = 1; tick(1); sw_reset = 0;
    check("R12", "count cleared", count, 0);
    check("R12", "flag cleared", ovf_flag, 0);
    check("R12", "readback cleared", clk_mode_rb, 0);
    tick(2);
    check("R12", "resumes from config", count, 1);
  endtask

  initial begin
    tick(2);
    rst_n = 1;
    tick(1);
    t_reset();
    t_wrap();
    t_prescale_stop();
    t_ext();
    t_start();
    t_pause();
    t_reload();
    t_stop();
    t_freeze();
    t_swreset();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule